// File: doc/BRIEF.md
# PRD table builder

This block converts a request made of scatter segments into the descriptor table that a bus-mastering disk DMA engine walks. Each segment arrives as a bus address and a byte length. Each descriptor (physical region descriptor, PRD) goes out as one beat on a valid/ready write port. A beat carries an address word and a count word. The builder cuts segments so that no descriptor runs across a 64 KiB address boundary. The count field is only 16 bits wide and some controllers misread a zero value, so a full 64 KiB piece is never encoded as zero.

A request ends with a segment flagged as last. Only then is it known which descriptor comes last, so the newest descriptor always waits in a one-entry holding register. It leaves when a newer descriptor displaces it, or when the request closes and it is stamped with the end marker. At the close the block pulses `done` and reports the descriptor count and two error flags. Either error means the caller should move the request by programmed I/O instead. A parameter selects an alternate count encoding that has no split and no end marker.

Top module: `prd_table_builder`

## Requirements
- R1: Every descriptor starts at the current segment address. Its byte size is the smaller of 0x10000 minus the address's low 16 bits and the bytes still left in the segment. Descriptors follow the segments in order and cover them without gaps.
- R2: A write beat carries one descriptor: the address on `wr_addr` and the count word on `wr_cnt`. In the standard format, `wr_cnt[15:0]` is the byte size and bits 30:16 are zero.
- R3: In the standard format, a 64 KiB piece becomes two descriptors, in this order: (address, 0x8000), then (address + 0x8000, 0x8000). A count field of 0x0000 is never produced.
- R4: In the standard format, bit 31 of `wr_cnt` is set on the final descriptor of a request and clear on every other descriptor.
- R5: If a request needs more than MAX_ENTRIES descriptors, the build aborts. `done` then comes with `err_ovf`=1 and `entry_count`=0. Exactly MAX_ENTRIES−1 descriptors have been written. The remaining segments up to the last one are taken in without output.
- R6: A request that needs exactly MAX_ENTRIES descriptors completes without error. Both halves of a split count toward the limit.
- R7: A request that yields no descriptors reports `err_empty`=1 and `entry_count`=0 with `done`.
- R8: With ALT_FMT=1, the count word is ((size[15:0] >> 2) − 1) modulo 2^16, placed in bits 31:16, and bits 15:0 are zero. There is no 64 KiB split and no end marker.
- R9: `seg_ready` is low while a segment is being cut into descriptors or the final descriptor is being flushed. No write beat is offered while `seg_ready` is high.
- R10: A zero-length segment produces no descriptor. If it is flagged last, it closes the request.
- R11: `done` is a one-cycle pulse. `entry_count` holds the number of descriptors in the table, and it and the error flags hold their values until the next `done`.
- R12: While `wr_valid` is high and `wr_ready` is low, the beat stays offered and unchanged.
- R13: After reset, `seg_ready` is 1 and `wr_valid`, `done`, `err_ovf` and `err_empty` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted this cycle when valid |
| seg_addr | input | ADDR_W | Segment bus address |
| seg_len | input | LEN_W | Segment length in bytes |
| seg_last | input | 1 | Segment closes the request |
| wr_valid | output | 1 | Descriptor beat offered |
| wr_ready | input | 1 | Table store accepts the beat |
| wr_addr | output | ADDR_W | Descriptor address word |
| wr_cnt | output | 32 | Descriptor count word |
| done | output | 1 | Request finished (one cycle) |
| entry_count | output | CNT_W = clog2(MAX_ENTRIES+1) | Descriptors in the table, 0 on error |
| err_ovf | output | 1 | Table capacity exceeded |
| err_empty | output | 1 | Request produced no descriptor |

## Verification
The bench builds two copies of the block, both with MAX_ENTRIES=8: one in the standard format (ALT_FMT=0) and one in the alternate format (ALT_FMT=1). The small capacity puts both capacity cases within reach of a handful of segments: a table filled exactly through 64 KiB splits, and an overflow that must drain a following segment. The alternate copy is given the same boundary-crossing and aligned 64 KiB patterns, so the missing split and the shifted count field show up directly. Pseudo-random stalls on the write port hold descriptors back, which exercises the holding register and the beat stability rule.

// File: rtl/prd_pkg.sv
package prd_pkg;

   localparam logic [16:0] SEG_SPAN  = 17'h1_0000;
   localparam logic [15:0] HALF_SPAN = 16'h8000;
   localparam logic [31:0] END_MARK  = 32'h8000_0000;

   typedef enum logic [2:0] {
      ST_IN,
      ST_SPLIT,
      ST_DRAIN,
      ST_FIN,
      ST_END
   } build_st_t;

   // alternate count encoding: (bytes/4 - 1) in the upper half word
   function automatic logic [31:0] alt_count_word(input logic [13:0] quads);
      logic [15:0] field;
      field = {2'b00, quads} - 16'd1;
      return {field, 16'h0000};
   endfunction

endpackage

// File: rtl/prd_chunk_calc.sv
module prd_chunk_calc #(
   parameter int LEN_W   = 32,
   parameter bit ALT_FMT = 1'b0
) (
   input  logic [15:0]      addr_lo,
   input  logic [LEN_W-1:0] rem,
   output logic [31:0]      cnt_word,
   output logic [LEN_W-1:0] step
);
   import prd_pkg::*;

   logic [16:0]      room;
   logic [LEN_W-1:0] room_ext;
   logic [LEN_W-1:0] piece;

   always_comb begin
      room     = SEG_SPAN - {1'b0, addr_lo};
      room_ext = LEN_W'(room);
      piece    = (rem < room_ext) ? rem : room_ext;
   end

   generate
      if (ALT_FMT) begin : g_alt
         always_comb begin
            cnt_word = alt_count_word(piece[15:2]);
            step     = piece;
         end
      end else begin : g_std
         logic full_span;
         always_comb begin
            full_span = piece[16];
            step      = full_span ? LEN_W'(HALF_SPAN) : piece;
            cnt_word  = {16'h0000, full_span ? HALF_SPAN : piece[15:0]};
         end
      end
   endgenerate

endmodule

// File: rtl/prd_entry_hold.sv
module prd_entry_hold #(
   parameter int ADDR_W   = 32,
   parameter bit END_FLAG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              fin,
   input  logic              drop,
   input  logic [ADDR_W-1:0] new_addr,
   input  logic [31:0]       new_cnt,
   output logic              push_ack,
   output logic              fin_ack,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [31:0]       wr_cnt
);
   import prd_pkg::*;

   logic              held_v;
   logic [ADDR_W-1:0] held_addr;
   logic [31:0]       held_cnt;
   logic [31:0]       end_bits;

   generate
      if (END_FLAG) begin : g_mark
         assign end_bits = fin ? END_MARK : 32'h0;
      end else begin : g_nomark
         assign end_bits = 32'h0;
      end
   endgenerate

   always_comb begin
      wr_valid = held_v && (push || fin);
      wr_addr  = held_addr;
      wr_cnt   = held_cnt | end_bits;
      push_ack = push && (!held_v || wr_ready);
      fin_ack  = fin  && (!held_v || wr_ready);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_v    <= 1'b0;
         held_addr <= '0;
         held_cnt  <= '0;
      end else if (drop) begin
         held_v <= 1'b0;
      end else if (push_ack) begin
         held_v    <= 1'b1;
         held_addr <= new_addr;
         held_cnt  <= new_cnt;
      end else if (fin_ack) begin
         held_v <= 1'b0;
      end
   end

endmodule

// File: rtl/prd_build_ctrl.sv
module prd_build_ctrl #(
   parameter int ADDR_W      = 32,
   parameter int LEN_W       = 32,
   parameter int MAX_ENTRIES = 256,
   localparam int CNT_W      = $clog2(MAX_ENTRIES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seg_valid,
   output logic              seg_ready,
   input  logic [ADDR_W-1:0] seg_addr,
   input  logic [LEN_W-1:0]  seg_len,
   input  logic              seg_last,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [LEN_W-1:0]  cur_rem,
   input  logic [LEN_W-1:0]  step,
   output logic              push,
   output logic              fin,
   output logic              drop,
   input  logic              push_ack,
   input  logic              fin_ack,
   output logic              done,
   output logic [CNT_W-1:0]  entry_count,
   output logic              err_ovf,
   output logic              err_empty
);
   import prd_pkg::*;

   localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_ENTRIES);

   build_st_t        state;
   logic             last_q;
   logic [CNT_W-1:0] cnt_q;
   logic             tbl_full;

   always_comb begin
      tbl_full  = (cnt_q == CAP);
      seg_ready = (state == ST_IN) || (state == ST_DRAIN);
      push      = (state == ST_SPLIT) && !tbl_full;
      drop      = (state == ST_SPLIT) &&  tbl_full;
      fin       = (state == ST_FIN);
      done      = (state == ST_END);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IN;
         cur_addr    <= '0;
         cur_rem     <= '0;
         last_q      <= 1'b0;
         cnt_q       <= '0;
         entry_count <= '0;
         err_ovf     <= 1'b0;
         err_empty   <= 1'b0;
      end else begin
         unique case (state)
            ST_IN: begin
               if (seg_valid) begin
                  cur_addr <= seg_addr;
                  cur_rem  <= seg_len;
                  last_q   <= seg_last;
                  if (seg_len != '0) state <= ST_SPLIT;
                  else if (seg_last)  state <= ST_FIN;
               end
            end
            ST_SPLIT: begin
               if (tbl_full) begin
                  entry_count <= '0;
                  err_ovf     <= 1'b1;
                  err_empty   <= 1'b0;
                  state       <= last_q ? ST_END : ST_DRAIN;
               end else if (push_ack) begin
                  cnt_q    <= cnt_q + CNT_W'(1);
                  cur_addr <= cur_addr + ADDR_W'(step);
                  cur_rem  <= cur_rem - step;
                  if (cur_rem == step) state <= last_q ? ST_FIN : ST_IN;
               end
            end
            ST_DRAIN: begin
               if (seg_valid && seg_last) state <= ST_END;
            end
            ST_FIN: begin
               if (fin_ack) begin
                  entry_count <= cnt_q;
                  err_ovf     <= 1'b0;
                  err_empty   <= (cnt_q == '0);
                  state       <= ST_END;
               end
            end
            ST_END: begin
               cnt_q <= '0;
               state <= ST_IN;
            end
            default: state <= ST_IN;
         endcase
      end
   end

endmodule

// File: rtl/prd_table_builder.sv
module prd_table_builder #(
   parameter int ADDR_W      = 32,
   parameter int LEN_W       = 32,
   parameter int MAX_ENTRIES = 256,
   parameter bit ALT_FMT     = 1'b0,
   localparam int CNT_W      = $clog2(MAX_ENTRIES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seg_valid,
   output logic              seg_ready,
   input  logic [ADDR_W-1:0] seg_addr,
   input  logic [LEN_W-1:0]  seg_len,
   input  logic              seg_last,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [31:0]       wr_cnt,
   output logic              done,
   output logic [CNT_W-1:0]  entry_count,
   output logic              err_ovf,
   output logic              err_empty
);

   generate
      if (ADDR_W < 17) begin : g_bad_addr
         $error("prd_table_builder: ADDR_W must be at least 17");
      end
      if (LEN_W < 17) begin : g_bad_len
         $error("prd_table_builder: LEN_W must be at least 17");
      end
      if (MAX_ENTRIES < 1) begin : g_bad_cap
         $error("prd_table_builder: MAX_ENTRIES must be positive");
      end
   endgenerate

   logic [ADDR_W-1:0] cur_addr;
   logic [LEN_W-1:0]  cur_rem;
   logic [LEN_W-1:0]  step;
   logic [31:0]       cnt_word;
   logic              push, fin, drop, push_ack, fin_ack;

   prd_build_ctrl #(
      .ADDR_W      (ADDR_W),
      .LEN_W       (LEN_W),
      .MAX_ENTRIES (MAX_ENTRIES)
   ) ctrl_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .seg_valid   (seg_valid),
      .seg_ready   (seg_ready),
      .seg_addr    (seg_addr),
      .seg_len     (seg_len),
      .seg_last    (seg_last),
      .cur_addr    (cur_addr),
      .cur_rem     (cur_rem),
      .step        (step),
      .push        (push),
      .fin         (fin),
      .drop        (drop),
      .push_ack    (push_ack),
      .fin_ack     (fin_ack),
      .done        (done),
      .entry_count (entry_count),
      .err_ovf     (err_ovf),
      .err_empty   (err_empty)
   );

   prd_chunk_calc #(
      .LEN_W   (LEN_W),
      .ALT_FMT (ALT_FMT)
   ) calc_i (
      .addr_lo  (cur_addr[15:0]),
      .rem      (cur_rem),
      .cnt_word (cnt_word),
      .step     (step)
   );

   prd_entry_hold #(
      .ADDR_W   (ADDR_W),
      .END_FLAG (!ALT_FMT)
   ) hold_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push),
      .fin      (fin),
      .drop     (drop),
      .new_addr (cur_addr),
      .new_cnt  (cnt_word),
      .push_ack (push_ack),
      .fin_ack  (fin_ack),
      .wr_valid (wr_valid),
      .wr_ready (wr_ready),
      .wr_addr  (wr_addr),
      .wr_cnt   (wr_cnt)
   );

endmodule

// File: rtl/prd_table_builder_chk.sv
module prd_table_builder_chk #(
   parameter int ADDR_W      = 32,
   parameter int LEN_W       = 32,
   parameter int MAX_ENTRIES = 256,
   parameter bit ALT_FMT     = 1'b0,
   localparam int CNT_W      = $clog2(MAX_ENTRIES + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              seg_ready,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [31:0]       wr_cnt,
   input logic              done,
   input logic [CNT_W-1:0]  entry_count,
   input logic              err_ovf,
   input logic              err_empty
);

   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_cnt))); // R12

   AST_BUSY_NO_SEG: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> !seg_ready); // R9

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R11

   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !wr_valid); // R11

   AST_OVF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err_ovf) |-> (entry_count == '0 && !err_empty)); // R5

   AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err_empty) |-> (entry_count == '0)); // R7

   AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (entry_count <= CNT_W'(MAX_ENTRIES))); // R6

   generate
      if (ALT_FMT) begin : g_alt
         AST_ALT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            wr_valid |-> (wr_cnt[15:0] == 16'h0000)); // R8
      end else begin : g_std
         AST_STD_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
            wr_valid |-> (wr_cnt[30:16] == 15'h0 && wr_cnt[15:0] != 16'h0000)); // R3
      end
   endgenerate

endmodule

bind prd_table_builder prd_table_builder_chk #(
   .ADDR_W      (ADDR_W),
   .LEN_W       (LEN_W),
   .MAX_ENTRIES (MAX_ENTRIES),
   .ALT_FMT     (ALT_FMT)
) chk_i (.*);

// File: tb/prd_table_builder_tb_top.sv
module prd_table_builder_tb_top;

   localparam int TB_MAX = 8;
   localparam int TB_CW  = $clog2(TB_MAX + 1);

   logic clk = 1'b0;
   always #5 clk = ~clk;
   logic rst_n;

   logic              seg_valid [2];
   logic              seg_ready [2];
   logic [31:0]       seg_addr  [2];
   logic [31:0]       seg_len   [2];
   logic              seg_last  [2];
   logic              wr_valid  [2];
   logic              wr_ready  [2];
   logic [31:0]       wr_addr   [2];
   logic [31:0]       wr_cnt    [2];
   logic              done      [2];
   logic [TB_CW-1:0]  entry_count [2];
   logic              err_ovf   [2];
   logic              err_empty [2];

   int unsigned exp_a   [2][$];
   int unsigned exp_c   [2][$];
   int unsigned res_cnt [2][$];
   bit          res_ovf [2][$];
   bit          res_emp [2][$];
   int          done_seen [2];
   int          reqs      [2];
   int          n_cmp = 0;
   int          n_bad = 0;
   int unsigned q_a [$];
   int unsigned q_l [$];

   task automatic chk(input bit ok, input string tag, input int unsigned act, input int unsigned exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   for (genvar g = 0; g < 2; g++) begin : g_dut
      prd_table_builder #(
         .MAX_ENTRIES (TB_MAX),
         .ALT_FMT     (g[0])
      ) dut_i (
         .clk         (clk),
         .rst_n       (rst_n),
         .seg_valid   (seg_valid[g]),
         .seg_ready   (seg_ready[g]),
         .seg_addr    (seg_addr[g]),
         .seg_len     (seg_len[g]),
         .seg_last    (seg_last[g]),
         .wr_valid    (wr_valid[g]),
         .wr_ready    (wr_ready[g]),
         .wr_addr     (wr_addr[g]),
         .wr_cnt      (wr_cnt[g]),
         .done        (done[g]),
         .entry_count (entry_count[g]),
         .err_ovf     (err_ovf[g]),
         .err_empty   (err_empty[g])
      );

      // stall pattern on the write port
      initial begin : stall_gen
         logic [7:0] lf;
         lf = 8'hA5 ^ 8'(g);
         wr_ready[g] = 1'b0;
         forever begin
            @(posedge clk);
            #2;
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            wr_ready[g] = lf[0] | lf[2];
         end
      end

      // scoreboard monitor
      initial begin : mon
         bit          pv;
         logic [31:0] pa, pc;
         int unsigned ea, ec, rc;
         bit          ro, re;
         pv = 1'b0;
         pa = '0;
         pc = '0;
         forever begin
            @(negedge clk);
            if (rst_n) begin
               if (pv)
                  chk(wr_valid[g] && wr_addr[g] == pa && wr_cnt[g] == pc,
                      "R12 stalled beat changed", wr_cnt[g], pc);
               pv = wr_valid[g] && !wr_ready[g];
               pa = wr_addr[g];
               pc = wr_cnt[g];
               if (wr_valid[g]) begin
                  chk(!seg_ready[g], "R9 segment input open during write", 32'(seg_ready[g]), 0);
                  if (wr_ready[g]) begin
                     if (exp_a[g].size() == 0) begin
                        chk(1'b0, "R5 unexpected descriptor", wr_addr[g], 0);
                     end else begin
                        ea = exp_a[g].pop_front();
                        ec = exp_c[g].pop_front();
                        chk(wr_addr[g] == ea, "R1 R2 address word", wr_addr[g], ea);
                        if (g == 0)
                           chk(wr_cnt[g] == ec, "R1 R3 R4 count word", wr_cnt[g], ec);
                        else
                           chk(wr_cnt[g] == ec, "R8 alternate count word", wr_cnt[g], ec);
                     end
                  end
               end
               if (done[g]) begin
                  if (res_cnt[g].size() == 0) begin
                     chk(1'b0, "R11 unexpected done", 1, 0);
                  end else begin
                     rc = res_cnt[g].pop_front();
                     ro = res_ovf[g].pop_front();
                     re = res_emp[g].pop_front();
                     chk(32'(entry_count[g]) == rc, "R11 R6 entry count", 32'(entry_count[g]), rc);
                     chk(err_ovf[g] == ro, "R5 overflow flag", 32'(err_ovf[g]), 32'(ro));
                     chk(err_empty[g] == re, "R7 empty flag", 32'(err_empty[g]), 32'(re));
                  end
                  done_seen[g]++;
               end
            end
         end
      end
   end

   // reference model: expected descriptors and outcome for q_a/q_l
   task automatic plan(input int i);
      int unsigned ea[$], ec[$];
      int unsigned a, l, bc, x;
      foreach (q_a[k]) begin
         a = q_a[k];
         l = q_l[k];
         while (l != 0) begin
            bc = 32'h1_0000 - (a & 32'hFFFF);
            if (bc > l) bc = l;
            x = bc & 32'hFFFF;
            if (i == 1) begin
               ea.push_back(a);
               ec.push_back(((x >> 2) - 1) << 16);
            end else if (x == 0) begin
               ea.push_back(a);          ec.push_back(32'h8000);
               ea.push_back(a + 32'h8000); ec.push_back(32'h8000);
            end else begin
               ea.push_back(a);
               ec.push_back(x);
            end
            a += bc;
            l -= bc;
         end
      end
      if (ea.size() > TB_MAX) begin
         for (int k = 0; k < TB_MAX - 1; k++) begin
            exp_a[i].push_back(ea[k]);
            exp_c[i].push_back(ec[k]);
         end
         res_cnt[i].push_back(0); res_ovf[i].push_back(1'b1); res_emp[i].push_back(1'b0);
      end else if (ea.size() == 0) begin
         res_cnt[i].push_back(0); res_ovf[i].push_back(1'b0); res_emp[i].push_back(1'b1);
      end else begin
         if (i == 0) ec[ec.size()-1] = ec[ec.size()-1] | 32'h8000_0000;
         foreach (ea[k]) begin
            exp_a[i].push_back(ea[k]);
            exp_c[i].push_back(ec[k]);
         end
         res_cnt[i].push_back(ea.size()); res_ovf[i].push_back(1'b0); res_emp[i].push_back(1'b0);
      end
      reqs[i]++;
   endtask

   task automatic drive_seg(input int i, input int unsigned a, input int unsigned l, input bit last);
      seg_valid[i] = 1'b1;
      seg_addr[i]  = a;
      seg_len[i]   = l;
      seg_last[i]  = last;
      do @(negedge clk); while (!seg_ready[i]);
      @(posedge clk);
      #2;
      seg_valid[i] = 1'b0;
   endtask

   task automatic send(input int i);
      plan(i);
      foreach (q_a[k]) drive_seg(i, q_a[k], q_l[k], k == q_a.size() - 1);
      q_a.delete();
      q_l.delete();
   endtask

   task automatic seg(input int unsigned a, input int unsigned l);
      q_a.push_back(a);
      q_l.push_back(l);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL R11 watchdog expired actual=hung expected=done");
      summary();
   end

   initial begin : main
      rst_n = 1'b0;
      for (int i = 0; i < 2; i++) begin
         seg_valid[i] = 1'b0;
         seg_addr[i]  = '0;
         seg_len[i]   = '0;
         seg_last[i]  = 1'b0;
         done_seen[i] = 0;
         reqs[i]      = 0;
      end
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 2; i++) begin
         chk(seg_ready[i] == 1'b1, "R13 seg_ready after reset", 32'(seg_ready[i]), 1);
         chk(!wr_valid[i] && !done[i], "R13 wr_valid/done after reset",
             32'({wr_valid[i], done[i]}), 0);
         chk(!err_ovf[i] && !err_empty[i], "R13 error flags after reset",
             32'({err_ovf[i], err_empty[i]}), 0);
      end
      @(posedge clk);
      #2;

      // standard format
      seg(32'h1000_0100, 32'h200);                    send(0); // R1 R4 single descriptor
      seg(32'h0000_FF00, 32'h300);                    send(0); // R1 boundary crossing
      seg(32'h0002_0000, 32'h1_0000);                 send(0); // R3 aligned 64 KiB split
      seg(32'h0000_5000, 32'h40);
      seg(32'h0000_6000, 32'h0);
      seg(32'h0007_FFF0, 32'h30);                     send(0); // R10 zero-length in middle
      seg(32'h0000_0000, 32'h0);                      send(0); // R7 R10 empty request
      seg(32'h0001_0000, 32'h4_0000);                 send(0); // R6 exactly eight via splits
      seg(32'h0000_0000, 32'h5_0000);
      seg(32'h0090_0000, 32'h100);                    send(0); // R5 overflow then drain
      seg(32'h0000_0000, 32'h4_0000);
      seg(32'h0050_0000, 32'h10);                     send(0); // R5 overflow on final segment
      seg(32'h0003_8004, 32'h1_0000);                 send(0); // R1 unaligned 64 KiB span

      // alternate format
      seg(32'h0000_FF00, 32'h300);                    send(1); // R8 boundary crossing
      seg(32'h0003_0000, 32'h1_0000);                 send(1); // R8 no split, no marker
      seg(32'h0000_1000, 32'h2);
      seg(32'h0000_2000, 32'h0);                      send(1); // R8 R10 tiny piece
      seg(32'h0000_0000, 32'h0);                      send(1); // R7 alternate empty

      wait (done_seen[0] == reqs[0] && done_seen[1] == reqs[1]);
      @(negedge clk);
      for (int i = 0; i < 2; i++)
         chk(exp_a[i].size() == 0, "R5 descriptors left unwritten", exp_a[i].size(), 0);
      summary();
   end

endmodule